// File: doc/BRIEF.md
# Staged Reset and Clock-Start Sequencer

This block brings a chip out of reset in stages. It controls three reset islands: the management logic, the clock/self-test/flush logic, and an on-chip PLL. While the active-low reset pin is low, all three islands are held in reset. When the pin is released, only the management island wakes. The PLL and the clock island wait for a one-cycle clock-start command from the management side.

A small PLL configuration register lives in the management clock domain, so software can program it while the core clock is still stopped. If software never touches the register, the block runs in external-PLL mode. In that mode the on-chip PLL stays in reset with bypass asserted, and clock start needs the external lock input to be high already.

If the register was written, the block runs in internal-PLL mode. Clock start first releases the PLL, then waits for lock within a programmable number of cycles, and only then frees the clock island. Every release edge is re-timed through a synchronizer, while every assertion takes effect at once. A status output flags a reset pulse that was too short to count as valid.

Top module: `staged_rst_seq`

## Requirements
- R1: If the reset pin is low for fewer than MIN_LOW (4) sampled clock cycles, `short_rst` goes high after release. A low phase of MIN_LOW or more cycles clears it. The flag is not cleared by the reset pin itself.
- R2: While `rst_pin_n` is low, `rst_mgmt_n`, `rst_clk_n` and `rst_pll_n` are all low, asynchronously and immediately.
- R3: After pin release, `rst_mgmt_n` goes high. `rst_pll_n` and `rst_clk_n` stay low until a clock-start command is accepted.
- R4: Config register layout: bit 0 selects the reference ratio (0 = half, 1 = quarter of the byte clock) and drives `ref_quarter`; bits [TO_W:1] hold the lock-timeout field. The register can be written after management release and reads back on `cfg_rdata`. Writes made after an accepted clock start are ignored.
- R5: If the register is never read or written after reset, `pll_bypass` is 1 and `rst_pll_n` stays 0. In this mode, clock start is accepted only if `pll_lock` (seen through a 2-flop synchronizer) is already high; otherwise it is ignored.
- R6: In internal mode, an accepted start releases the PLL reset first. The clock island is released only after lock is seen. With a timeout field value f and no lock, `lock_to` rises f+1 cycles after the accepting edge, and `rst_clk_n` stays low.
- R7: In internal mode, a start command that arrives when the register has been read but never written is ignored. It sets `seq_err`, which stays set until a pin reset.
- R8: Once the clock island is released, `running` is 1. Further start commands have no effect, and `running` stays set until a pin reset.
- R9: Each island reset rises through a two-flop synchronizer, 2 clock edges after its internal release: after pin release, after start acceptance, or after the lock-accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management bus clock |
| rst_pin_n | input | 1 | Active-low reset pin |
| cfg_wr | input | 1 | Config register write strobe |
| cfg_rd | input | 1 | Config register read strobe |
| cfg_wdata | input | TO_W+1 | Config write data |
| cfg_rdata | output | TO_W+1 | Config register contents |
| start_cmd | input | 1 | One-cycle clock-start command |
| pll_lock | input | 1 | PLL lock indication (asynchronous) |
| rst_mgmt_n | output | 1 | Management island reset, active low |
| rst_clk_n | output | 1 | Clock/self-test/flush island reset, active low |
| rst_pll_n | output | 1 | PLL island reset, active low |
| pll_bypass | output | 1 | On-chip PLL bypassed (external mode) |
| ref_quarter | output | 1 | Reference ratio select: 1 = quarter, 0 = half |
| running | output | 1 | Clock island released |
| short_rst | output | 1 | Last reset pulse was too short |
| seq_err | output | 1 | Start issued before the PLL register was written |
| lock_to | output | 1 | Lock wait timed out |

## Verification
The bench builds the block with its default parameters: a 10-bit timeout field, two synchronizer stages, and a four-cycle minimum reset. With these, the timeout boundary can be checked cycle-exactly for random field values, including the 1024-cycle maximum. Pulse widths of 2, 3 and 4 cycles probe both sides of the short-reset threshold. Random register values mixed with lock-or-timeout outcomes exercise the internal path, and directed cases cover the external path and the sequence error.

// File: rtl/staged_rst_seq.sv
module staged_rst_seq #(
  parameter int TO_W    = 10,
  parameter int SYNC_N  = 2,
  parameter int MIN_LOW = 4
) (
  input  logic          clk,
  input  logic          rst_pin_n,
  input  logic          cfg_wr,
  input  logic          cfg_rd,
  input  logic [TO_W:0] cfg_wdata,
  output logic [TO_W:0] cfg_rdata,
  input  logic          start_cmd,
  input  logic          pll_lock,
  output logic          rst_mgmt_n,
  output logic          rst_clk_n,
  output logic          rst_pll_n,
  output logic          pll_bypass,
  output logic          ref_quarter,
  output logic          running,
  output logic          short_rst,
  output logic          seq_err,
  output logic          lock_to
);
  localparam int CW = $clog2(MIN_LOW + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_FAIL} st_t;
  st_t st;

  logic [TO_W:0]   pll_reg;
  logic [TO_W-1:0] timer;
  logic            touched, written, rel_pll, rel_clk;
  logic [1:0]      lock_sy;
  logic [2:0]      rel_req, rel_out;

  // pin-width monitor: deliberately outside the pin reset
  logic [1:0]    pin_sy;
  logic [CW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    pin_sy <= {pin_sy[0], rst_pin_n};
    if (pin_sy[1]) low_cnt <= '0;
    else if (low_cnt != CW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
    if (pin_sy[0] && !pin_sy[1]) short_rst <= (int'(low_cnt) < MIN_LOW - 1);
  end

  assign rel_req = {rel_pll, rel_clk, 1'b1};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    logic [SYNC_N-1:0] sh;
    always_ff @(posedge clk or negedge rst_pin_n)
      if (!rst_pin_n) sh <= '0;
      else            sh <= {sh[SYNC_N-2:0], rel_req[i]};
    assign rel_out[i] = sh[SYNC_N-1];
  end

  assign rst_mgmt_n  = rel_out[0];
  assign rst_clk_n   = rel_out[1];
  assign rst_pll_n   = rel_out[2];
  assign cfg_rdata   = pll_reg;
  assign ref_quarter = pll_reg[0];
  assign pll_bypass  = !touched;
  assign running     = (st == S_RUN);
  assign lock_to     = (st == S_FAIL);

  wire cfg_ok  = (st == S_IDLE) && rst_mgmt_n;
  wire lock_ok = lock_sy[1];

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) lock_sy <= '0;
    else            lock_sy <= {lock_sy[0], pll_lock};

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      st      <= S_IDLE;
      pll_reg <= '0;
      timer   <= '0;
      touched <= 1'b0;
      written <= 1'b0;
      rel_pll <= 1'b0;
      rel_clk <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      if (cfg_ok && (cfg_wr || cfg_rd)) touched <= 1'b1;
      if (cfg_ok && cfg_wr) begin
        pll_reg <= cfg_wdata;
        written <= 1'b1;
      end
      case (st)
        S_IDLE:
          if (start_cmd && rst_mgmt_n) begin
            if (!touched) begin
              if (lock_ok) begin
                st      <= S_RUN;
                rel_clk <= 1'b1;
              end
            end else if (!written) begin
              seq_err <= 1'b1;
            end else begin
              st      <= S_WAIT;
              rel_pll <= 1'b1;
              timer   <= '0;
            end
          end
        S_WAIT:
          if (lock_ok) begin
            st      <= S_RUN;
            rel_clk <= 1'b1;
          end else if (timer == pll_reg[TO_W:1]) begin
            st <= S_FAIL;
          end else begin
            timer <= timer + 1'b1;
          end
        default: ;
      endcase
    end
  end

  // R2: pin low holds every island
  p_pin_low_all_r2: assert property (@(posedge clk)
    !rst_pin_n |-> !(rst_mgmt_n || rst_clk_n || rst_pll_n));

  // R3: nothing beyond management leaves reset before a start was accepted
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (st == S_IDLE) |-> (!rst_clk_n && !rst_pll_n));

  // R4: register frozen once the start was accepted
  p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (st != S_IDLE) |=> $stable(cfg_rdata));

  // R5: bypass keeps the PLL in reset
  p_bypass_pll_held_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pll_bypass |-> !rst_pll_n);

  // R6: clock island never ahead of the PLL in internal mode, never after timeout
  p_pll_first_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (rst_clk_n && !pll_bypass) |-> rst_pll_n);
  p_timeout_holds_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    lock_to |-> !rst_clk_n);

  // R7: sequence error is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    seq_err |=> seq_err);

  // R8: running is sticky
  p_running_sticky_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    running |=> running);

  // R9: a release edge is never immediate
  p_sync_release_r9: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(rst_clk_n) |-> $past(running));
endmodule

// File: tb/staged_rst_seq_test.sv
module staged_rst_seq_test;
  localparam int CLK_P = 10;
  localparam int TO_W  = 10;

  logic clk = 0, rst_pin_n = 0, cfg_wr = 0, cfg_rd = 0, start_cmd = 0, pll_lock = 0;
  logic [TO_W:0] cfg_wdata = '0, cfg_rdata;
  logic rst_mgmt_n, rst_clk_n, rst_pll_n, pll_bypass, ref_quarter, running;
  logic short_rst, seq_err, lock_to;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  staged_rst_seq #(.TO_W(TO_W)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .start_cmd(start_cmd),
    .pll_lock(pll_lock), .rst_mgmt_n(rst_mgmt_n), .rst_clk_n(rst_clk_n),
    .rst_pll_n(rst_pll_n), .pll_bypass(pll_bypass), .ref_quarter(ref_quarter),
    .running(running), .short_rst(short_rst), .seq_err(seq_err), .lock_to(lock_to));

  function automatic logic exp_ratio(logic [TO_W:0] v); return v[0]; endfunction
  function automatic int exp_wait(logic [TO_W:0] v); return int'(v[TO_W:1]) + 1; endfunction
  function automatic logic exp_short(int n); return n < 4; endfunction

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pin_reset(int n);
    @(negedge clk); rst_pin_n = 0; pll_lock = 0;
    #1 chk("R2 islands held", {rst_mgmt_n, rst_clk_n, rst_pll_n}, 0);
    repeat (n) @(negedge clk);
    rst_pin_n = 1;
    @(negedge clk); chk("R9 mgmt one edge", rst_mgmt_n, 0);
    repeat (3) @(negedge clk);
    chk("R3 mgmt released", rst_mgmt_n, 1);
    chk("R1 short flag", short_rst, exp_short(n));
  endtask

  task automatic wr(logic [TO_W:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); cfg_rd = 1;
    @(negedge clk); cfg_rd = 0;
  endtask

  task automatic start();
    @(negedge clk); start_cmd = 1;
    @(negedge clk); start_cmd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1 chk("R2 power-up held", {rst_mgmt_n, rst_clk_n, rst_pll_n}, 0);
    repeat (6) @(negedge clk);
    rst_pin_n = 1;
    @(negedge clk); chk("R9 mgmt after one edge", rst_mgmt_n, 0);
    @(negedge clk); chk("R9 mgmt after two edges", rst_mgmt_n, 1);
    repeat (4) @(negedge clk);
    chk("R3 pll held", rst_pll_n, 0);
    chk("R3 clk held", rst_clk_n, 0);
    chk("R1 long reset", short_rst, 0);
    chk("R5 bypass", pll_bypass, 1);

    // external mode: start without lock is ignored
    start(); repeat (4) @(negedge clk);
    chk("R5 start w/o lock", running, 0);
    chk("R5 clk held w/o lock", rst_clk_n, 0);
    pll_lock = 1; repeat (3) @(negedge clk);
    start();
    chk("R8 running", running, 1);
    chk("R9 clk not yet", rst_clk_n, 0);
    @(negedge clk); @(negedge clk);
    chk("R9 clk released", rst_clk_n, 1);
    chk("R5 pll still held", rst_pll_n, 0);
    wr(11'h155); start(); repeat (3) @(negedge clk);
    chk("R4 write after start", cfg_rdata, 0);
    chk("R8 still running", running, 1);
    chk("R5 bypass kept", pll_bypass, 1);

    // short pulses
    pin_reset(2);
    pin_reset(3);
    chk("R8 cleared by pin", running, 0);
    pin_reset(4);

    // read-only then start: sequence error
    rd(); start(); repeat (3) @(negedge clk);
    chk("R7 seq_err", seq_err, 1);
    chk("R7 pll held", rst_pll_n, 0);
    chk("R5 bypass off after read", pll_bypass, 0);
    wr(11'h00D); start(); repeat (2) @(negedge clk);
    chk("R7 sticky", seq_err, 1);
    chk("R6 pll released", rst_pll_n, 1);
    pin_reset(5);
    chk("R7 cleared", seq_err, 0);

    // random internal-mode runs
    for (int k = 0; k < 10; k++) begin
      logic [TO_W:0] v;
      bit lock_ok = $urandom_range(0, 1) == 1;
      int f = lock_ok ? $urandom_range(6, 40) : $urandom_range(0, 40);
      if (k == 9) begin lock_ok = 0; f = 1023; end
      v = {TO_W'(f), 1'($urandom_range(0, 1))};
      pin_reset(4 + $urandom_range(0, 3));
      wr(v);
      chk("R4 readback", cfg_rdata, v);
      chk("R4 ratio", ref_quarter, exp_ratio(v));
      start();
      if (lock_ok) begin
        @(negedge clk);
        chk("R9 pll one edge", rst_pll_n, 0);
        @(negedge clk);
        chk("R6 pll first", rst_pll_n, 1);
        chk("R6 clk waits", rst_clk_n, 0);
        pll_lock = 1;
        repeat (6) @(negedge clk);
        chk("R6 clk after lock", rst_clk_n, 1);
        chk("R8 running", running, 1);
        wr(~v); start(); repeat (exp_wait(v)) @(negedge clk);
        chk("R6 no timeout", lock_to, 0);
        chk("R4 frozen", cfg_rdata, v);
        chk("R8 stays", running, 1);
      end else begin
        if (exp_wait(v) > 1) begin
          repeat (exp_wait(v) - 1) @(negedge clk);
          chk("R6 before timeout", lock_to, 0);
        end
        @(negedge clk);
        chk("R6 timeout edge", lock_to, 1);
        repeat (3) @(negedge clk);
        chk("R6 clk held", rst_clk_n, 0);
        chk("R6 not running", running, 0);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule